// File: doc/BRIEF.md
# Read Strobe Pulse Shortener

This block conditions the read strobe that a processor sends to a flash array. In pass-through mode the strobe reaches the array unchanged. In shortening mode each assertion of the strobe is cut down to a short one-shot pulse of fixed absolute duration, so the array draws read current for only as long as it needs, however slow the processor clock is.

The pulse width is counted in cycles of a fast reference clock (nominally 96 MHz) and not in processor cycles. Two widths can be selected, about 40 ns and about 66 ns. Each is rounded up to whole reference cycles, which gives 4 and 7 cycles at the default parameters. A pulse is triggered by the rising edge of the strobe. It ends when the counted width runs out or when the strobe drops, whichever happens first. The mode and width controls are sampled only at a strobe rising edge that triggers a new access. Software is expected to choose pass-through when the processor clock runs above 10 MHz, and the block does not enforce this.

Top module: `rd_strobe_shaper`

## Requirements
- R1: In pass-through mode (`pass_en` = 1 sampled at the triggering edge), `strobe_out` equals `strobe_in` in every cycle, with no register delay.
- R2: In shortening mode (`pass_en` = 0 sampled at the triggering edge), `strobe_out` rises in the same reference cycle in which the rising edge of `strobe_in` is first seen.
- R3: With `wide_sel` = 0 and a long enough strobe, `strobe_out` stays high for exactly 4 reference cycles (40 ns rounded up at 96 MHz) and then goes low.
- R4: With `wide_sel` = 1 and a long enough strobe, `strobe_out` stays high for exactly 7 reference cycles (66 ns rounded up at 96 MHz) and then goes low.
- R5: If `strobe_in` falls before the counted width runs out, `strobe_out` falls with it. It does not rise again inside that pulse window, even if the strobe rises again.
- R6: A strobe rising edge that arrives while a pulse window is still counting neither restarts nor extends the window. After the window ends, a strobe that is still high leaves `strobe_out` low.
- R7: `pass_en` and `wide_sel` are sampled only at a strobe rising edge that starts a new access. Changing them while the strobe is high, or during a pulse window, has no effect on the current access.
- R8: During and after reset, with `strobe_in` low, `strobe_out` is low and no pulse window is counting.
- R9: `strobe_out` is never high while `strobe_in` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock that times the pulse width |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_in | input | 1 | Raw read strobe from the processor, active high |
| pass_en | input | 1 | 1 = pass-through, 0 = shorten each access |
| wide_sel | input | 1 | 1 = long pulse width, 0 = short pulse width |
| strobe_out | output | 1 | Conditioned read strobe to the flash array |

## Verification
The assertions assume that `strobe_in` is synchronous to the reference clock and holds each level for at least one full reference cycle. A change that falls between two clock edges would go unseen by the edge detector and the truncation flag. The bench therefore drives every input only at the falling clock edge and holds it for whole cycles. Strobe high and low phases are drawn at random with lengths of one cycle or more. The controls are flipped at random inside strobe phases, so the stimulus covers the sampling rule without breaking the timing assumption.

// File: rtl/rsps_pkg.sv
package rsps_pkg;
  // Whole reference cycles needed to cover a pulse, rounded up.
  function automatic int unsigned cycles_for(input int unsigned pulse_ps,
                                             input int unsigned ref_ps);
    return (pulse_ps + ref_ps - 1) / ref_ps;
  endfunction
endpackage

// File: rtl/rsps_edge.sv
module rsps_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= strb_i;
  end

  assign rise_o = strb_i & ~level_q;
endmodule

// File: rtl/rsps_oneshot.sv
module rsps_oneshot #(
  parameter int unsigned W_SHORT = 4,
  parameter int unsigned W_LONG  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_i,
  input  logic rise_i,
  input  logic pass_i,
  input  logic wide_i,
  output logic start_o,
  output logic busy_o,
  output logic cut_o,
  output logic pass_q_o
);
  localparam int unsigned CW       = (W_LONG > 2) ? $clog2(W_LONG) : 1;
  localparam int unsigned LOAD_S   = W_SHORT - 2;
  localparam int unsigned LOAD_L   = W_LONG - 2;

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          cut_q;
  logic          pass_q;

  assign start_o  = rise_i && !busy_q;
  assign busy_o   = busy_q;
  assign cut_o    = cut_q;
  assign pass_q_o = pass_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      cut_q  <= 1'b0;
      pass_q <= 1'b0;
    end else if (start_o) begin
      pass_q <= pass_i;
      cut_q  <= 1'b0;
      if (!pass_i) begin
        busy_q <= 1'b1;
        cnt_q  <= wide_i ? CW'(LOAD_L) : CW'(LOAD_S);
      end
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
      if (!strb_i)     cut_q  <= 1'b1;
    end
  end

  // R3/R4: the counter never holds more than the long load value.
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= CW'(LOAD_L)));

  // R6: a window that is counting only counts down, even when a new rising edge arrives.
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

  // R7: the latched mode holds while a window is counting.
  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> $stable(pass_q));

  // R5: once the strobe has dropped, the truncation stays set for the rest of the window.
  assert_cut_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0 && cut_q) |=> cut_q);
endmodule

// File: rtl/rsps_outsel.sv
module rsps_outsel (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_i,
  input  logic start_i,
  input  logic pass_i,
  input  logic pass_q_i,
  input  logic busy_i,
  input  logic cut_i,
  output logic strb_o
);
  logic mode_pass;
  logic armed;

  always_comb begin
    mode_pass = start_i ? pass_i : pass_q_i;
    armed     = start_i || (busy_i && !cut_i);
    strb_o    = strb_i && (mode_pass || armed);
  end

  // R9: the conditioned strobe is never high without the raw strobe.
  assert_out_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strb_o |-> strb_i);

  // R2: in shortening mode a new access drives the output high at once.
  assert_start_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !pass_i) |-> strb_o);
endmodule

// File: rtl/rd_strobe_shaper.sv
module rd_strobe_shaper #(
  parameter int unsigned REF_PERIOD_PS  = 10417,
  parameter int unsigned SHORT_PULSE_PS = 40000,
  parameter int unsigned LONG_PULSE_PS  = 66000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  input  logic pass_en,
  input  logic wide_sel,
  output logic strobe_out
);
  import rsps_pkg::*;

  localparam int unsigned W_SHORT = cycles_for(SHORT_PULSE_PS, REF_PERIOD_PS);
  localparam int unsigned W_LONG  = cycles_for(LONG_PULSE_PS, REF_PERIOD_PS);

  logic rise;
  logic start;
  logic busy;
  logic cut;
  logic pass_q;

  rsps_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb_i (strobe_in),
    .rise_o (rise)
  );

  rsps_oneshot #(.W_SHORT(W_SHORT), .W_LONG(W_LONG)) u_shot (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb_i   (strobe_in),
    .rise_i   (rise),
    .pass_i   (pass_en),
    .wide_i   (wide_sel),
    .start_o  (start),
    .busy_o   (busy),
    .cut_o    (cut),
    .pass_q_o (pass_q)
  );

  rsps_outsel u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb_i   (strobe_in),
    .start_i  (start),
    .pass_i   (pass_en),
    .pass_q_i (pass_q),
    .busy_i   (busy),
    .cut_i    (cut),
    .strb_o   (strobe_out)
  );

  // R8: the output is low in every cycle in which the raw strobe is low.
  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_in |-> !strobe_out);
endmodule

// File: tb/rd_strobe_shaper_tb.sv
module rd_strobe_shaper_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_in = 1'b0;
  logic pass_en = 1'b0;
  logic wide_sel = 1'b0;
  logic strobe_out;

  int n_checks = 0;
  int n_fail = 0;
  int cyc_cnt = 0;

  // Bench reference state, built from the requirements
  logic m_prev = 1'b0;
  int   m_left = 0;
  logic m_cut = 1'b0;
  logic m_pass = 1'b0;
  logic m_wide = 1'b0;

  always #2 clk = ~clk;

  rd_strobe_shaper u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in),
    .pass_en(pass_en), .wide_sel(wide_sel), .strobe_out(strobe_out)
  );

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: act=timeout exp=finished");
      finish_run();
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: strobe_out act=%0b exp=%0b (cycle %0d)", tag, act, exp, cyc_cnt);
    end
  endtask

  function automatic int width_of(input logic w);
    return w ? 7 : 4;
  endfunction

  // One reference cycle: drive at the falling edge, then check against the model.
  task automatic cyc(input logic s, input logic p, input logic w, input string tag);
    logic rise;
    logic exp;
    string t;
    @(negedge clk);
    strobe_in = s; pass_en = p; wide_sel = w;
    #1;
    rise = s && !m_prev;
    if (rise && m_left == 0) begin
      m_pass = p;
      m_wide = w;
      m_cut  = 1'b0;
      if (!p) m_left = width_of(w);
    end
    exp = m_pass ? s : (m_left > 0 && !m_cut && s);
    if (tag == "") t = m_pass ? "R1" : (m_wide ? "R4" : "R3");
    else           t = tag;
    check(t, strobe_out, exp);
    if (!s && strobe_out) check("R9", strobe_out, 1'b0);
    if (m_left > 0 && !s) m_cut = 1'b1;
    m_prev = s;
    if (m_left > 0) m_left--;
  endtask

  // Holds the strobe high for len cycles with fixed controls and counts output-high cycles.
  task automatic pulse_count(input int len, input logic p, input logic w,
                             input string tag, input int exp_hi);
    int hi = 0;
    for (int i = 0; i < len; i++) begin
      cyc(1'b1, p, w, tag);
      if (strobe_out) hi++;
    end
    n_checks++;
    if (hi != exp_hi) begin
      n_fail++;
      $display("FAIL %s: high cycles act=%0d exp=%0d", tag, hi, exp_hi);
    end
    for (int i = 0; i < 8; i++) cyc(1'b0, p, w, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R8: output low while in reset and just after release
    repeat (3) @(negedge clk);
    #1 check("R8", strobe_out, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, "R8");

    // R2/R3: short width, first cycle high
    cyc(1'b1, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 11; i++) cyc(1'b1, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, "R3");
    pulse_count(12, 1'b0, 1'b0, "R3", 4);
    pulse_count(12, 1'b0, 1'b1, "R4", 7);
    pulse_count(10, 1'b1, 1'b0, "R1", 10);
    // R5: strobe shorter than the window
    pulse_count(2, 1'b0, 1'b1, "R5", 2);
    // R5/R6: drop and rise again inside the window, no second pulse
    cyc(1'b1, 1'b0, 1'b1, "R5");
    cyc(1'b1, 1'b0, 1'b1, "R5");
    cyc(1'b0, 1'b0, 1'b1, "R5");
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1, 1'b0, 1'b1, "R6");
      check("R6", strobe_out, 1'b0);
    end
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 1'b0, "R6");
    // R7: flip controls during a held strobe
    cyc(1'b1, 1'b0, 1'b0, "R7");
    for (int i = 0; i < 9; i++) begin
      cyc(1'b1, 1'b1, 1'b1, "R7");
      if (i >= 3) check("R7", strobe_out, 1'b0);
    end
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, "R7");
    // R7: pass-through latched, then control cleared mid-strobe
    cyc(1'b1, 1'b1, 1'b0, "R7");
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 1'b1, "R7");
    check("R7", strobe_out, 1'b1);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, "R7");

    // Random phases, with control changes inside them
    for (int seg = 0; seg < 500; seg++) begin
      int hi_len = 1 + int'($urandom % 10);
      int lo_len = 1 + int'($urandom % 6);
      logic p = ($urandom % 4) == 0;
      logic w = $urandom % 2;
      for (int i = 0; i < hi_len; i++) begin
        if ($urandom % 5 == 0) p = ~p;
        if ($urandom % 5 == 0) w = ~w;
        cyc(1'b1, p, w, "");
      end
      for (int i = 0; i < lo_len; i++) cyc(1'b0, $urandom % 2, $urandom % 2, "");
    end
    finish_run();
  end
endmodule